// File: doc/BRIEF.md
# Masked Circular Trace Address Generator

This block gives the physical byte address for each outgoing trace byte when trace output is confined to one contiguous range whose size is a power of two and whose start is aligned to that size. Software programs two 64-bit registers while tracing is off. The first is a base register. The second is a pointer register. Its low 32 bits hold a mask that gives the range size minus one, and its high 32 bits hold the starting write offset. Each byte address is formed as (base AND NOT mask) + (offset AND mask). The offset therefore moves through the masked window and returns to zero after it reaches the mask.

When the enable input rises, the block checks the configuration. It rejects three cases: a mask that is not of the form 2^k-1, a base that has a 1 in any bit the mask also has set, and an offset larger than the mask. A bad configuration sends the control machine to its fault state. In that state the error output is high and no bytes are accepted until software drops the enable. A good configuration sends the machine to its running state. In that state every byte taken over the valid/ready handshake advances the offset by one. The high half of the pointer register always shows the live offset, so software can read back where tracing stopped.

The control machine has three states. IDLE is held while the enable is low. RUN accepts bytes. FAULT reports a configuration error. The transitions are: IDLE to RUN (enable high and the configuration is clean), IDLE to FAULT (enable high and any check fails), RUN to IDLE (enable low), and FAULT to IDLE (enable low).

Top module: `trace_addr_gen`

## Requirements
- R1: After reset the machine is in IDLE, `trace_err` and `byte_ready` are 0, and both registers read as zero (`ptr_rdata` is 0).
- R2: A write with `cfg_we`=1 loads the base register when `cfg_sel`=0 and the pointer register when `cfg_sel`=1. The pointer register holds the mask in bits [31:0] and the offset in bits [63:32]. A write takes effect only in a cycle where `trace_en` is 0, and is ignored otherwise.
- R3: While `byte_ready` is 1, `byte_addr` equals (base AND NOT zext(mask)) + zext(offset AND mask).
- R4: On the first cycle with `trace_en` high in IDLE, a mask with a 0 bit below its highest 1 bit sends the machine to FAULT.
- R5: A base that shares any set bit with the zero-extended mask sends the machine to FAULT on that same enable cycle. A base whose lowest set bit lies just above the mask is accepted.
- R6: An offset greater than the mask sends the machine to FAULT. An offset equal to the mask is accepted.
- R7: The configuration is checked in the first clock cycle in which `trace_en` is high. `trace_err` (FAULT) or `byte_ready` (RUN) goes high in the next cycle. `trace_err` stays 1 while `trace_en` stays high, and is 0 in the cycle after `trace_en` is seen low.
- R8: `byte_ready` is 1 only in RUN with `trace_en` high. In FAULT or IDLE no byte is accepted, and the offset in `ptr_rdata` does not change.
- R9: Each accepted byte (`byte_valid` and `byte_ready`) sets the offset to (offset+1) AND mask. It wraps to 0 after the mask value, and `ptr_rdata[63:32]` always shows the current offset.
- R10: A mask of 0 with offset 0 is valid. Every accepted byte then goes to the base address and the offset stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the pointer register |
| cfg_wdata | input | 64 | Register write data |
| trace_en | input | 1 | Tracing enable; its rising edge triggers the configuration check |
| byte_valid | input | 1 | A trace byte is offered |
| byte_ready | output | 1 | The byte is taken this cycle |
| byte_addr | output | 64 | Physical address for the offered byte |
| trace_err | output | 1 | Configuration error; tracing is halted |
| ptr_rdata | output | 64 | Pointer register readback: {live offset, mask} |

## Verification
The bench goes after the window edges. The first edge is the step from offset == mask back to zero. A design that gets it wrong would write past the window or skip the bottom address. The second edge is the all-ones 32-bit mask, where a mask check that adds one without a carry bit would wrongly reject a valid window. The third edge is the empty mask, which must hold every byte at the base. The configuration checks are tested on both sides of each limit: offset equal to versus one above the mask, and base bits touching versus just clearing the mask. A design with an off-by-one comparison would fault on a legal setup or run with an illegal one. The bench also checks that register writes made while enabled, and bytes offered while faulted, leave the readback offset unchanged. A design that leaks either would corrupt the resume point.

// File: rtl/trace_addr_pkg.sv
package trace_addr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } trc_state_e;

    typedef struct packed {
        logic bad_shape;
        logic overlap;
        logic off_over;
    } cfg_fault_t;

endpackage

// File: rtl/trace_cfg_check.sv
module trace_cfg_check
    import trace_addr_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic [2*PTR_W-1:0] base_i,
    input  logic [PTR_W-1:0]   mask_i,
    input  logic [PTR_W-1:0]   off_i,
    output cfg_fault_t         fault_o
);
    localparam int ADDR_W = 2 * PTR_W;

    // A rising step (bit i set, bit i-1 clear) means a hole below a 1.
    logic [PTR_W-1:0] step_up;

    assign step_up[0] = 1'b0;
    for (genvar gi = 1; gi < PTR_W; gi++) begin : g_step
        assign step_up[gi] = mask_i[gi] & ~mask_i[gi-1];
    end

    logic [ADDR_W-1:0] mask_ext;
    assign mask_ext = {{(ADDR_W-PTR_W){1'b0}}, mask_i};

    always_comb begin
        fault_o.bad_shape = |step_up;
        fault_o.overlap   = |(base_i & mask_ext);
        fault_o.off_over  = (off_i > mask_i);
    end

endmodule

// File: rtl/trace_addr_calc.sv
module trace_addr_calc #(
    parameter int PTR_W = 32
) (
    input  logic [2*PTR_W-1:0] base_i,
    input  logic [PTR_W-1:0]   mask_i,
    input  logic [PTR_W-1:0]   off_i,
    output logic [2*PTR_W-1:0] addr_o
);
    localparam int ADDR_W = 2 * PTR_W;
    localparam int PAD_W  = ADDR_W - PTR_W;

    logic [ADDR_W-1:0] mask_ext;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        mask_ext = {{PAD_W{1'b0}}, mask_i};
        off_ext  = {{PAD_W{1'b0}}, off_i & mask_i};
        addr_o   = (base_i & ~mask_ext) + off_ext;
    end

endmodule

// File: rtl/trace_addr_gen.sv
module trace_addr_gen
    import trace_addr_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [2*PTR_W-1:0]   cfg_wdata,
    input  logic                 trace_en,
    input  logic                 byte_valid,
    output logic                 byte_ready,
    output logic [2*PTR_W-1:0]   byte_addr,
    output logic                 trace_err,
    output logic [2*PTR_W-1:0]   ptr_rdata
);
    localparam int ADDR_W = 2 * PTR_W;

    trc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [PTR_W-1:0]  mask_q;
    logic [PTR_W-1:0]  off_q;
    cfg_fault_t        faults;
    logic              cfg_bad;
    logic              accept;

    trace_cfg_check #(.PTR_W(PTR_W)) i_check (
        .base_i  (base_q),
        .mask_i  (mask_q),
        .off_i   (off_q),
        .fault_o (faults)
    );

    trace_addr_calc #(.PTR_W(PTR_W)) i_calc (
        .base_i (base_q),
        .mask_i (mask_q),
        .off_i  (off_q),
        .addr_o (byte_addr)
    );

    assign cfg_bad = faults.bad_shape | faults.overlap | faults.off_over;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (trace_en) state_d = cfg_bad ? ST_FAULT : ST_RUN;
            ST_RUN:   if (!trace_en) state_d = ST_IDLE;
            ST_FAULT: if (!trace_en) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        byte_ready = (state_q == ST_RUN) && trace_en;
        trace_err  = (state_q == ST_FAULT);
        ptr_rdata  = {off_q, mask_q};
    end

    assign accept = byte_valid && byte_ready;

    // Configuration registers and live offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            off_q  <= '0;
        end else if (cfg_we && !trace_en) begin
            if (cfg_sel) begin
                mask_q <= cfg_wdata[PTR_W-1:0];
                off_q  <= cfg_wdata[ADDR_W-1:PTR_W];
            end else begin
                base_q <= cfg_wdata;
            end
        end else if (accept) begin
            off_q <= (off_q + 1'b1) & mask_q;
        end
    end

    // R8
    no_accept_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trace_err |-> !byte_ready)
        else $error("byte_ready high while faulted");

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_err && trace_en) |=> trace_err)
        else $error("error dropped while enable high");

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> !trace_err)
        else $error("error held after enable low");

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && off_q == mask_q) |=> (off_q == '0))
        else $error("offset failed to wrap to zero");

    // R9
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && off_q != mask_q) |=> (off_q == $past(off_q) + 1'b1))
        else $error("offset did not advance by one");

    // R8
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && !accept) |=> $stable(off_q))
        else $error("offset moved without an accepted byte");

    // R6
    run_offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (off_q <= mask_q))
        else $error("offset beyond mask while running");

    // R3
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> ((byte_addr & ~{{PTR_W{1'b0}}, mask_q}) == base_q))
        else $error("address left the aligned window");

endmodule

// File: tb/test_trace_addr_gen.sv
module test_trace_addr_gen;
    localparam int PW = 32;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          trace_en = 1'b0;
    logic          byte_valid = 1'b0;
    logic          byte_ready;
    logic [AW-1:0] byte_addr;
    logic          trace_err;
    logic [AW-1:0] ptr_rdata;

    always #4 clk = ~clk;

    trace_addr_gen #(.PTR_W(PW)) i_trace_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .trace_en   (trace_en),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .byte_addr  (byte_addr),
        .trace_err  (trace_err),
        .ptr_rdata  (ptr_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference: 0 idle, 1 run, 2 fault
    int          m_st = 0;
    logic [63:0] m_base = '0;
    logic [31:0] m_mask = '0;
    logic [31:0] m_off = '0;

    function automatic bit shape_bad(logic [31:0] m);
        int top = -1;
        for (int i = 0; i < 32; i++) if (m[i]) top = i;
        for (int i = 0; i < top; i++) if (!m[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_base = '0; m_mask = '0; m_off = '0;
        end else begin
            if (cfg_we && !trace_en) begin
                if (cfg_sel) begin m_mask = cfg_wdata[31:0]; m_off = cfg_wdata[63:32]; end
                else m_base = cfg_wdata;
            end
            case (m_st)
                0: if (trace_en) begin
                       if (shape_bad(m_mask) || ((m_base & {32'd0, m_mask}) != 0) || (m_off > m_mask))
                           m_st = 2;
                       else
                           m_st = 1;
                   end
                1: begin
                       if (!trace_en) m_st = 0;
                       else if (byte_valid) m_off = (m_off + 1) & m_mask;
                   end
                default: if (!trace_en) m_st = 0;
            endcase
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
        if (rst_n) begin
            logic exp_rdy;
            exp_rdy = (m_st == 1) && trace_en;
            check("R8 ready", {63'd0, byte_ready}, {63'd0, exp_rdy});
            check("R7 err", {63'd0, trace_err}, {63'd0, m_st == 2});
            check("R9 ptr", ptr_rdata, {m_off, m_mask});
            if (exp_rdy)
                check("R3 addr", byte_addr, (m_base & ~{32'd0, m_mask}) + {32'd0, m_off & m_mask});
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(logic sel, logic [63:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic off_all();
        trace_en = 1'b0; byte_valid = 1'b0;
        step();
    endtask

    // Enable with a given setup and report whether the machine faulted
    task automatic try_cfg(logic [63:0] b, logic [63:0] p, logic exp_err, string tag);
        wr(1'b0, b);
        wr(1'b1, p);
        trace_en = 1'b1; byte_valid = 1'b1;
        step();
        @(negedge clk);
        check(tag, {63'd0, trace_err}, {63'd0, exp_err});
        step(3);
        @(negedge clk);
        if (exp_err)
            check({tag, " offset frozen (R8)"}, ptr_rdata, p);
        off_all();
        @(negedge clk);
        check({tag, " cleared (R7)"}, {63'd0, trace_err}, 64'd0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 err", {63'd0, trace_err}, 64'd0);
        check("R1 ready", {63'd0, byte_ready}, 64'd0);
        check("R1 ptr", ptr_rdata, 64'd0);

        // Streaming through a 256-byte window starting near its top
        wr(1'b0, 64'h0000_00AB_CD00_0000);
        wr(1'b1, {32'h0000_00FC, 32'h0000_00FF});
        trace_en = 1'b1; byte_valid = 1'b1;
        step();
        @(negedge clk);
        check("R7 ready next cycle", {63'd0, byte_ready}, 64'd1);
        step(10);
        @(negedge clk);
        check("R9 wrap offset", ptr_rdata, {32'h0000_0006, 32'h0000_00FF});
        byte_valid = 1'b0;
        wr(1'b1, 64'h0);
        @(negedge clk);
        check("R2 write ignored while enabled", ptr_rdata, {32'h0000_0006, 32'h0000_00FF});
        for (int i = 0; i < 12; i++) begin
            byte_valid = (i % 3) != 1;
            step();
        end
        off_all();

        // Configuration checks on both sides of each limit
        try_cfg(64'h0, {32'h0, 32'h0000_00F0}, 1'b1, "R4 holed mask");
        try_cfg(64'h0, {32'h0, 32'h0000_0105}, 1'b1, "R4 split mask");
        try_cfg(64'h0000_0000_0001_0010, {32'h0, 32'h0000_00FF}, 1'b1, "R5 overlap");
        try_cfg(64'h0000_0000_0000_0100, {32'h0, 32'h0000_00FF}, 1'b0, "R5 adjacent ok");
        try_cfg(64'h0, {32'h0000_0010, 32'h0000_000F}, 1'b1, "R6 offset over");
        try_cfg(64'h0, {32'h0000_000F, 32'h0000_000F}, 1'b0, "R6 offset equal ok");

        // Empty window
        wr(1'b0, 64'h1234_5678_9ABC_DEF0);
        wr(1'b1, 64'h0);
        trace_en = 1'b1; byte_valid = 1'b1;
        step();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 fixed addr", byte_addr, 64'h1234_5678_9ABC_DEF0);
            step();
        end
        @(negedge clk);
        check("R10 offset stays 0", ptr_rdata, 64'h0);
        off_all();

        // Full 32-bit window wrapping
        wr(1'b0, 64'hABCD_0000_0000_0000);
        wr(1'b1, {32'hFFFF_FFFE, 32'hFFFF_FFFF});
        trace_en = 1'b1; byte_valid = 1'b1;
        step();
        @(negedge clk);
        check("R4 all-ones mask accepted", {63'd0, trace_err}, 64'd0);
        check("R3 top addr", byte_addr, 64'hABCD_0000_FFFF_FFFE);
        step(3);
        @(negedge clk);
        check("R9 full wrap", ptr_rdata, {32'h0000_0001, 32'hFFFF_FFFF});
        off_all();
        step(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule